// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control path and storage of a pipelined burst SRAM whose words are made of byte lanes, each lane eight data bits plus a parity bit. An access starts on one of two address strobes. The processor strobe is gated by the first chip select and wins over the controller strobe. Three chip selects qualify the access. Once an access is running, further cycles either continue the burst or suspend it, under an advance input. A two-bit sequencer walks the low address bits in linear or interleaved order, and the order is chosen by a static strap input.

Writes are controlled by a global write input and by a byte-write enable with one select per lane. The global write overrides the lane selects. Read data passes through a synchronous array read and then an output register, so it is seen one cycle after the address is taken. The output-drive flag is forced low when the device is deselected. It stays low for the first cycle of an access that follows a deselect. Apart from that, the asynchronous output enable gates it combinationally.

The data bus is split into an input word, an output word and a drive flag, so that the pads stay outside the block.

Top module: `pbsram_ctl`

## Requirements
- R1: An access started at clock edge k on a read (either strobe honoured, all chip selects active, global write and byte-write enable both high) presents the addressed word on `rd_data` after edge k+1, with `rd_drive` high when `oe_n` is low.
- R2: When both strobes are low and `ce1_n` is low, only the processor strobe acts, and the cycle is a read whatever the write inputs are.
- R3: The processor strobe has no effect while `ce1_n` is high. If the controller strobe is high in such a cycle, an active burst continues as if no strobe were low.
- R4: A controller-strobe start with `gw_n` low, or with `bwe_n` low, writes `wr_data` at that same edge to the given address.
- R5: A processor-strobe start ignores the write and advance inputs at its own edge and reads the address. A write presented at the next edge, with both strobes high, goes to that same address.
- R6: With `gw_n` low, a write updates every lane regardless of `bwe_n` and `bw_n`.
- R7: With `gw_n` high and `bwe_n` low, only lanes whose `bw_n` bit is low are written. Lane i is bits [9i+8:9i], so lane 0 is [8:0] and lane 1 is [17:9]. Other lanes keep their contents.
- R8: Each continue cycle with `adv_n` low steps the low two address bits. With `linear_mode` high the sequence is start+n modulo 4, and with it low the sequence is start XOR n. It wraps after four steps, and the upper address bits never change.
- R9: A continue cycle with `adv_n` high re-accesses the current burst address.
- R10: A strobe with any chip select inactive deselects the device, and `rd_drive` is low after that edge. The first cycle of an access that starts from the deselected state, or from reset, also has `rd_drive` low.
- R11: `oe_n` acts combinationally on `rd_drive` in the same cycle and does not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| linear_mode | input | 1 | Static burst order strap: 1 linear, 0 interleaved |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_drive | output | 1 | High when the block drives the data bus |

## Verification
A write takes effect at the edge that samples it, so a read started on the next edge already returns the new word. A read started at edge k is sampled on `rd_data` one nanosecond after edge k+1. The drive flag is checked one nanosecond after the deselecting edge, and again after the first edge of the following access. The bench drives and samples one nanosecond after each rising edge and keeps a word-by-word reference array, merged lane by lane from the write masks it computes. A burst is checked word by word as it streams: after edge i the output must hold the word that edge i-1 addressed, so the final idle edge shows the wrapped address.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef struct packed {
    logic start_p;  // processor strobe honoured
    logic sel;      // all chip selects active
    logic new_acc;  // access begins this edge
    logic desel;    // strobe with chip select inactive
    logic cont;     // no strobe, burst running
    logic adv;      // advance the burst counter
    op_e  op;
  } dec_t;

  // Low address bits at burst step n from a start value.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       linear);
    logic [1:0] r;
    if (linear) r = start + n;
    else        r = start ^ n;
    return r;
  endfunction

endpackage

// File: rtl/pbsram_decode.sv
module pbsram_decode
  import pbsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             active,
  output dec_t             dec,
  output logic [LANES-1:0] lane_we
);

  logic start_p, start_c, start, sel, wr_req;

  always_comb begin
    start_p = !adsp_n && !ce1_n;
    start_c = !adsc_n && !start_p;
    start   = start_p || start_c;
    sel     = !ce1_n && ce2 && !ce3_n;
    wr_req  = !gw_n || !bwe_n;

    dec         = '0;
    dec.start_p = start_p;
    dec.sel     = sel;
    dec.new_acc = start && sel;
    dec.desel   = start && !sel;
    dec.cont    = !start && active;
    dec.adv     = dec.cont && !adv_n;

    if (dec.new_acc)   dec.op = (start_c && wr_req) ? OP_WRITE : OP_READ;
    else if (dec.cont) dec.op = wr_req ? OP_WRITE : OP_READ;
    else               dec.op = OP_NONE;

    if (dec.op != OP_WRITE) lane_we = '0;
    else if (!gw_n)         lane_we = '1;
    else if (!bwe_n)        lane_we = ~bw_n;
    else                    lane_we = '0;
  end

endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst
  import pbsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] load_lo,
  input  logic       step_en,
  input  logic       linear,
  output logic [1:0] cur_lo,
  output logic [1:0] nxt_lo
);

  logic [1:0] start_q, cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      start_q <= load_lo;
      cnt_q   <= '0;
    end else if (step_en) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign cur_lo = burst_lo(start_q, cnt_q, linear);
  assign nxt_lo = burst_lo(start_q, cnt_q + 2'd1, linear);

endmodule

// File: rtl/pbsram_store.sv
module pbsram_store #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    re,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) arr[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)         rd_q      <= arr[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/pbsram_ctl.sv
module pbsram_ctl
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    linear_mode,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - 2;

  dec_t              dec;
  logic [LANES-1:0]  lane_we;
  logic              active;
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        cur_lo, nxt_lo;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] out_q;
  logic              rd_pend, out_live;

  // Named events for the checker.
  logic ev_start_p, ev_sel, ev_desel, ev_cont, ev_read;
  assign ev_start_p = dec.start_p;
  assign ev_sel     = dec.sel;
  assign ev_desel   = dec.desel;
  assign ev_cont    = dec.cont;
  assign ev_read    = (dec.op == OP_READ);

  pbsram_decode #(.LANES(LANES)) u_dec (
    .adsp_n (adsp_n), .adsc_n (adsc_n), .adv_n (adv_n),
    .ce1_n  (ce1_n),  .ce2    (ce2),    .ce3_n (ce3_n),
    .gw_n   (gw_n),   .bwe_n  (bwe_n),  .bw_n  (bw_n),
    .active (active), .dec    (dec),    .lane_we (lane_we)
  );

  pbsram_burst u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (dec.new_acc),
    .load_lo (addr[1:0]),
    .step_en (dec.adv),
    .linear  (linear_mode),
    .cur_lo  (cur_lo),
    .nxt_lo  (nxt_lo)
  );

  always_comb begin
    if (dec.new_acc)  eff_addr = addr;
    else if (dec.adv) eff_addr = {hi_q, nxt_lo};
    else              eff_addr = {hi_q, cur_lo};
  end

  pbsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .addr    (eff_addr),
    .lane_we (lane_we),
    .re      (ev_read),
    .wdata   (wr_data),
    .rdata   (arr_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      hi_q     <= '0;
      rd_pend  <= 1'b0;
      out_live <= 1'b0;
    end else begin
      if (dec.new_acc) begin
        active <= 1'b1;
        hi_q   <= addr[ADDR_W-1:2];
      end else if (dec.desel) begin
        active <= 1'b0;
      end
      rd_pend  <= ev_read;
      out_live <= rd_pend && !dec.desel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       out_q <= '0;
    else if (rd_pend) out_q <= arr_rd;
  end

  assign rd_data  = out_q;
  assign rd_drive = out_live && !oe_n;

endmodule

// File: rtl/pbsram_ctl_chk.sv
module pbsram_ctl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adsc_n,
  input logic             gw_n,
  input logic             ev_start_p,
  input logic             ev_sel,
  input logic             ev_desel,
  input logic             ev_cont,
  input logic [LANES-1:0] lane_we,
  input logic             rd_pend,
  input logic             out_live,
  input logic             active
);

  // R5
  adsp_first_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_p && ev_sel) |-> (lane_we == '0));

  // R2
  strobe_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_p && !adsc_n) |-> (lane_we == '0));

  // R6
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cont && !gw_n) |-> (&lane_we));

  // R10
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> !out_live);

  // R10
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> !active);

  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !ev_desel) |=> out_live);

endmodule

bind pbsram_ctl pbsram_ctl_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adsc_n     (adsc_n),
  .gw_n       (gw_n),
  .ev_start_p (ev_start_p),
  .ev_sel     (ev_sel),
  .ev_desel   (ev_desel),
  .ev_cont    (ev_cont),
  .lane_we    (lane_we),
  .rd_pend    (rd_pend),
  .out_live   (out_live),
  .active     (active)
);

// File: tb/tb_pbsram_ctl.sv
`timescale 1ns/1ps
module tb_pbsram_ctl;

  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n;
  logic          gw_n, bwe_n, oe_n, linear_mode;
  logic [LN-1:0] bw_n;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_drive;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [DW-1:0] ref_mem [WORDS];

  always #2.5 clk = ~clk;

  pbsram_ctl #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk (clk), .rst_n (rst_n), .addr (addr),
    .adsp_n (adsp_n), .adsc_n (adsc_n), .adv_n (adv_n),
    .ce1_n (ce1_n), .ce2 (ce2), .ce3_n (ce3_n),
    .gw_n (gw_n), .bwe_n (bwe_n), .bw_n (bw_n),
    .oe_n (oe_n), .linear_mode (linear_mode),
    .wr_data (wr_data), .rd_data (rd_data), .rd_drive (rd_drive)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 9341 + salt * 577 + 677) % (1 << DW));
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LN-1:0] m);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < LN; l++)
      if (m[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [1:0] seq_lo(input int s, input int n, input bit lin);
    return lin ? 2'((s + n) % 4) : 2'(s ^ (n % 4));
  endfunction

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write started by the controller strobe; reference merged by mask.
  task automatic wr_c(input int a, input logic [DW-1:0] d,
                      input bit g, input bit be, input logic [1:0] b);
    logic [LN-1:0] m;
    idle();
    adsc_n = 1'b0; addr = AW'(a); gw_n = g; bwe_n = be; bw_n = b; wr_data = d;
    step();
    idle();
    m = !g ? '1 : (!be ? ~b : '0);
    ref_mem[a] = merge(ref_mem[a], d, m);
  endtask

  task automatic rd_c(input int a, input string req);
    idle();
    adsc_n = 1'b0; addr = AW'(a);
    step();
    idle();
    step();
    chk(req, rd_data, ref_mem[a]);
    chk(req, DW'(rd_drive), DW'(1));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] old_w, jw, dw;
    idle();
    linear_mode = 1'b1;
    addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    chk("R10 reset float", DW'(rd_drive), DW'(0));

    // R10: first cycle of first access after reset floats.
    wr_c(0, pat(0, 1), 1'b0, 1'b1, 2'b11);
    chk("R10 first cycle after reset", DW'(rd_drive), DW'(0));

    // R4: fill every word with controller-strobe writes.
    for (int a = 1; a < WORDS; a++) wr_c(a, pat(a, 1), 1'b0, 1'b1, 2'b11);
    // R1: read every word back.
    for (int a = 0; a < WORDS; a++) rd_c(a, "R1/R4 read after fill");

    // R6/R7: sweep all write-control combinations.
    for (int c = 0; c < 16; c++) begin
      wr_c(32 + c, pat(c, 3), c[3], c[2], 2'(c));
      rd_c(32 + c, "R6/R7 lane mask");
    end

    // R8: bursts in both orders from every start offset.
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        int base = 16 + 4 * s;
        linear_mode = lin[0];
        idle();
        adsp_n = 1'b0; addr = AW'(base + s);
        step();
        for (int i = 1; i <= 4; i++) begin
          idle(); adv_n = 1'b0;
          step();
          chk("R8 burst order", rd_data, ref_mem[base + seq_lo(s, i - 1, lin[0])]);
        end
        idle();
        step();
        chk("R8 burst wrap", rd_data, ref_mem[base + seq_lo(s, 4, lin[0])]);
      end
    end

    // R9: suspend holds the burst address.
    linear_mode = 1'b1;
    idle(); adsc_n = 1'b0; addr = AW'(8);
    step();
    idle(); step();
    chk("R9 suspend first", rd_data, ref_mem[8]);
    idle(); adv_n = 1'b0; step();
    chk("R9 suspend held", rd_data, ref_mem[8]);
    idle(); step();
    chk("R9 after advance", rd_data, ref_mem[9]);

    // R3: processor strobe with ce1_n high acts as a continue.
    idle(); adsc_n = 1'b0; addr = AW'(8);
    step();
    idle(); adsp_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; addr = AW'(40);
    step();
    idle(); step();
    chk("R3 ignored strobe continues", rd_data, ref_mem[9]);
    chk("R3 drive kept", DW'(rd_drive), DW'(1));

    // R2: both strobes low, processor wins, write inputs ignored.
    old_w = ref_mem[12];
    idle(); adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = AW'(12); wr_data = ~old_w;
    step();
    idle(); step();
    chk("R2 priority read", rd_data, old_w);
    rd_c(12, "R2 word unchanged");

    // R5: processor-strobe write, controls ignored in first cycle.
    old_w = ref_mem[20];
    jw = pat(99, 7); dw = pat(55, 5);
    idle(); adsp_n = 1'b0; gw_n = 1'b0; adv_n = 1'b0; addr = AW'(20); wr_data = jw;
    step();
    idle(); bwe_n = 1'b0; bw_n = 2'b10; wr_data = dw;
    step();
    chk("R5 first cycle reads", rd_data, old_w);
    idle(); step();
    ref_mem[20] = merge(old_w, dw, 2'b01);
    rd_c(20, "R5 second-edge write");
    rd_c(21, "R5 no advance");

    // R11: output enable is combinational.
    rd_c(30, "R11 setup");
    oe_n = 1'b1; #1;
    chk("R11 oe high floats", DW'(rd_drive), DW'(0));
    chk("R11 data held", rd_data, ref_mem[30]);
    oe_n = 1'b0; #1;
    chk("R11 oe low drives", DW'(rd_drive), DW'(1));

    // R10: deselect floats at once, next access floats its first cycle.
    rd_c(5, "R10 setup");
    idle(); adsc_n = 1'b0; ce2 = 1'b0;
    step();
    chk("R10 deselect float", DW'(rd_drive), DW'(0));
    idle(); step();
    chk("R10 stays idle", DW'(rd_drive), DW'(0));
    idle(); adsc_n = 1'b0; addr = AW'(7);
    step();
    chk("R10 first cycle float", DW'(rd_drive), DW'(0));
    idle(); step();
    chk("R10 data after", rd_data, ref_mem[7]);
    chk("R10 drive after", DW'(rd_drive), DW'(1));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule